// File: doc/BRIEF.md
# Cycle-Synchronous DC Offset Canceller

This block removes a slowly drifting DC level from a stream of signed ADC samples that carry a received square-wave probe. The local probe generator's excitation state comes in as a reference signal, so the block does not need to find the signal's periods by analysing the samples. A rising edge on that reference starts a new excitation period. The block then sums exactly 2^LOG2_N samples. The sum shifted right by LOG2_N is that period's DC estimate. The estimate is recomputed from scratch every period, so a sudden step in the DC level is fully tracked after one period.

A mode input selects where each estimate is applied. In same-period mode, the samples of a period are written to an internal buffer. When the period closes, they are replayed one per clock with that period's own estimate subtracted. In next-period mode, there is no buffering: every incoming sample leaves one cycle later, minus the estimate of the most recent completed period. In both modes, results are saturated to the sample width.

Top module: `cyc_dc_cancel`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first result is produced.
- R2: The reference input passes through a two-flop synchronizer. A rising edge seen after the synchronizer arms a new period. The first accepted sample in or after that cycle is sample 0 of the period.
- R3: A period closes on its 2^LOG2_N-th sample. Its estimate is floor(sum / 2^LOG2_N), which is an arithmetic right shift of the full-width sum.
- R4: With `mode_same` = 1, closing a period starts a replay. The replay presents 2^LOG2_N results on consecutive cycles, in arrival order. Each result is sample_i minus that same period's estimate.
- R5: With `mode_same` = 0, each accepted sample yields exactly one result on the next cycle. The result is the sample minus the estimate of the last period that closed before that sample.
- R6: No result is produced until a first period has closed. In next-period mode, the samples of the first period produce no output.
- R7: Each result is clamped to the range [-2^(W-1), 2^(W-1)-1].
- R8: A reference rising edge that arrives before a period has collected all its samples discards that partial period. Its samples affect no estimate and, in same-period mode, are never output.
- R9: A sample accepted in the same cycle as the synchronized rising edge is sample 0 of the new period.
- R10: In same-period mode, samples that arrive after a period has closed and before the next rising edge produce no output and enter no estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Excitation state from the local probe generator (asynchronous) |
| mode_same | input | 1 | 1: subtract the estimate from its own period (buffered); 0: subtract it from the following period |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | W (16) | Signed ADC sample |
| out_valid | output | 1 | One-cycle strobe per result |
| out_sample | output | W (16) | Signed, saturated offset-free sample |

## Verification
Two events can land in the same cycle. The first pair is the synchronized rising reference edge and an accepted sample. The bench provokes this by raising the reference exactly two falling clock edges before it drives a sample. The scoreboard then expects that sample to head a fresh period, with the aborted partial period leaving no trace. The second pair is a replay read of the buffer and a write from the following period. In same-period mode the bench starts the next period right after one closes, so the next period's samples are written while the replay is still in progress. Every replayed value must still match the estimate and contents of its own period.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    parameter int DCC_SAMPLE_W = 16;
    parameter int DCC_LOG2_N   = 8;

    typedef enum logic {
        MODE_NEXT = 1'b0,
        MODE_SAME = 1'b1
    } dcc_mode_e;
endpackage

// File: rtl/dcc_ref_edge.sv
module dcc_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = ref_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/dcc_period_acc.sv
module dcc_period_acc #(
    parameter int W      = dcc_pkg::DCC_SAMPLE_W,
    parameter int LOG2_N = dcc_pkg::DCC_LOG2_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    output logic                wr_en,
    output logic [LOG2_N-1:0]   wr_idx,
    output logic                closing,
    output logic signed [W-1:0] est_q,
    output logic                have_est_q,
    output logic                active_q,
    output logic [LOG2_N-1:0]   cnt_q
);
    localparam int AW = W + LOG2_N;
    localparam logic [LOG2_N-1:0] LAST_IDX = {LOG2_N{1'b1}};

    typedef struct packed {
        logic                 armed;
        logic                 active;
        logic [LOG2_N-1:0]    cnt;
        logic signed [AW-1:0] acc;
        logic signed [W-1:0]  est;
        logic                 have_est;
    } acc_t;

    acc_t st_d, st_q;

    logic                 start;
    logic                 take;
    logic [LOG2_N-1:0]    idx;
    logic signed [AW-1:0] smp_ext;
    logic signed [AW-1:0] acc_in;

    always_comb begin
        start   = rise | st_q.armed;
        take    = in_valid & (start | st_q.active);
        idx     = start ? '0 : st_q.cnt;
        smp_ext = {{LOG2_N{in_sample[W-1]}}, in_sample};
        acc_in  = start ? smp_ext : st_q.acc + smp_ext;
        closing = take & (idx == LAST_IDX);

        st_d = st_q;
        if (rise) begin
            st_d.armed  = 1'b1;
            st_d.active = 1'b0;
        end
        if (take) begin
            st_d.armed  = 1'b0;
            st_d.active = ~closing;
            st_d.cnt    = idx + 1'b1;
            st_d.acc    = acc_in;
            if (closing) begin
                st_d.est      = acc_in[AW-1:LOG2_N];
                st_d.have_est = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en      = take;
    assign wr_idx     = idx;
    assign est_q      = st_q.est;
    assign have_est_q = st_q.have_est;
    assign active_q   = st_q.active;
    assign cnt_q      = st_q.cnt;
endmodule

// File: rtl/dcc_sample_buf.sv
module dcc_sample_buf #(
    parameter int W      = dcc_pkg::DCC_SAMPLE_W,
    parameter int LOG2_N = dcc_pkg::DCC_LOG2_N
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LOG2_N-1:0] wr_idx,
    input  logic [W-1:0]      wr_data,
    input  logic [LOG2_N-1:0] rd_idx,
    output logic [W-1:0]      rd_data
);
    localparam int DEPTH = 1 << LOG2_N;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dcc_sat_sub.sv
module dcc_sat_sub #(
    parameter int W = dcc_pkg::DCC_SAMPLE_W
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] diff;

    always_comb begin
        diff = {a[W-1], a} - {b[W-1], b};
        if (diff[W] != diff[W-1]) y = diff[W] ? MIN_V : MAX_V;
        else                      y = diff[W-1:0];
    end
endmodule

// File: rtl/cyc_dc_cancel.sv
module cyc_dc_cancel #(
    parameter int W      = dcc_pkg::DCC_SAMPLE_W,
    parameter int LOG2_N = dcc_pkg::DCC_LOG2_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_in,
    input  logic                mode_same,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    output logic                out_valid,
    output logic signed [W-1:0] out_sample
);
    import dcc_pkg::*;

    localparam logic [LOG2_N-1:0] LAST_IDX = {LOG2_N{1'b1}};

    typedef struct packed {
        logic                rep_active;
        logic [LOG2_N-1:0]   rep_idx;
        logic                out_valid;
        logic signed [W-1:0] out_sample;
    } top_t;

    top_t st_d, st_q;

    logic                rise;
    logic                wr_en;
    logic [LOG2_N-1:0]   wr_idx;
    logic                closing;
    logic signed [W-1:0] est_q;
    logic                have_est_q;
    logic                acc_active;
    logic [LOG2_N-1:0]   acc_cnt;
    logic [W-1:0]        buf_rd;
    logic signed [W-1:0] sub_a;
    logic signed [W-1:0] sub_y;
    logic                same_sel;
    logic                pass_en;
    logic                rep_busy;
    logic [LOG2_N-1:0]   rep_pos;

    dcc_ref_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .rise   (rise)
    );

    dcc_period_acc #(.W(W), .LOG2_N(LOG2_N)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .closing    (closing),
        .est_q      (est_q),
        .have_est_q (have_est_q),
        .active_q   (acc_active),
        .cnt_q      (acc_cnt)
    );

    dcc_sample_buf #(.W(W), .LOG2_N(LOG2_N)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_sample),
        .rd_idx  (st_q.rep_idx),
        .rd_data (buf_rd)
    );

    assign sub_a = st_q.rep_active ? buf_rd : in_sample;

    dcc_sat_sub #(.W(W)) u_sub (
        .a (sub_a),
        .b (est_q),
        .y (sub_y)
    );

    always_comb begin
        same_sel = (mode_same == MODE_SAME);
        pass_en  = in_valid & ~same_sel & have_est_q;

        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (st_q.rep_active) begin
            st_d.out_valid  = 1'b1;
            st_d.out_sample = sub_y;
            st_d.rep_idx    = st_q.rep_idx + 1'b1;
            if (st_q.rep_idx == LAST_IDX) st_d.rep_active = 1'b0;
        end else if (pass_en) begin
            st_d.out_valid  = 1'b1;
            st_d.out_sample = sub_y;
        end
        if (closing && same_sel) begin
            st_d.rep_active = 1'b1;
            st_d.rep_idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.out_valid;
    assign out_sample = st_q.out_sample;
    assign rep_busy   = st_q.rep_active;
    assign rep_pos    = st_q.rep_idx;
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
    parameter int LOG2_N = dcc_pkg::DCC_LOG2_N
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mode_same,
    input logic              out_valid,
    input logic              rise,
    input logic              closing,
    input logic              have_est,
    input logic              rep_busy,
    input logic [LOG2_N-1:0] rep_pos,
    input logic              acc_active,
    input logic [LOG2_N-1:0] acc_cnt
);
    // R6
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> have_est);

    // R5
    next_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_same && in_valid && have_est && !rep_busy) |=> out_valid);

    // R4
    replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && mode_same) |=> (rep_busy && rep_pos == '0));

    // R4
    replay_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_busy |=> out_valid);

    // R9
    edge_sample_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && in_valid) |=> (acc_active && acc_cnt == 1));

    // R8
    edge_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !in_valid) |=> !acc_active);
endmodule

bind cyc_dc_cancel dcc_chk #(.LOG2_N(LOG2_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode_same  (mode_same),
    .out_valid  (out_valid),
    .rise       (rise),
    .closing    (closing),
    .have_est   (have_est_q),
    .rep_busy   (rep_busy),
    .rep_pos    (rep_pos),
    .acc_active (acc_active),
    .acc_cnt    (acc_cnt)
);

// File: tb/tb_cyc_dc_cancel.sv
module tb_cyc_dc_cancel;
    localparam int W  = 16;
    localparam int LG = 8;
    localparam int N  = 1 << LG;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ref_in = 1'b0;
    logic                mode_same = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic                out_valid;
    logic signed [W-1:0] out_sample;

    always #5 clk = ~clk;

    cyc_dc_cancel #(.W(W), .LOG2_N(LG)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .mode_same  (mode_same),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    typedef struct {
        int    val;
        string req;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    int    outs_seen = 0;
    bit    finished = 0;
    string tag = "R4";

    bit     m_armed, m_active, m_have;
    longint m_sum;
    int     m_est;
    int     m_buf[$];

    function automatic int clip(int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic void push_exp(int raw);
        exp_t e;
        e.val = clip(raw);
        e.req = (e.val != raw) ? "R7" : tag;
        q.push_back(e);
    endfunction

    function automatic void check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            outs_seen++;
            if (q.size() == 0) begin
                check(1'b0, "R6 unexpected result", int'(out_sample), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(out_sample) == e.val, e.req, int'(out_sample), e.val);
            end
        end
    end

    task automatic do_reset();
        rst_n    = 1'b0;
        ref_in   = 1'b0;
        in_valid = 1'b0;
        m_armed = 0; m_active = 0; m_have = 0; m_sum = 0; m_est = 0;
        m_buf.delete();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        check(out_sample == '0, "R1 sample", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after release", int'(out_valid), 0);
    endtask

    // coincide=1 places the next sample in the cycle of the synchronized edge (R9)
    task automatic raise_ref(bit coincide);
        ref_in = 1'b0;
        repeat (4) @(negedge clk);
        ref_in   = 1'b1;
        m_armed  = 1;
        m_active = 0;
        if (coincide) @(negedge clk);
        else          repeat (4) @(negedge clk);
    endtask

    task automatic send(int v);
        if (!mode_same && m_have) push_exp(v - m_est);
        if (m_armed || m_active) begin
            if (m_armed) begin
                m_armed = 0; m_active = 1; m_sum = 0;
                m_buf.delete();
            end
            m_buf.push_back(v);
            m_sum += v;
            if (m_buf.size() == N) begin
                m_est    = int'(m_sum >>> LG);   // R3 floor mean
                m_have   = 1;
                m_active = 0;
                if (mode_same) foreach (m_buf[i]) push_exp(m_buf[i] - m_est);
            end
        end
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = W'(v);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic drain();
        repeat (N + 20) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int base;
        mode_same = 1'b1;
        do_reset();

        // R3/R4: rising ramp, mean not an integer, then back-to-back negative period
        tag = "R3";
        raise_ref(0);
        for (int i = 0; i < N; i++) send(i * 123 - 15000);
        tag = "R4";
        raise_ref(0);
        for (int i = 0; i < N; i++) send(-i * 7 - 3);
        drain();
        check(q.size() == 0, "R4 replay count", q.size(), 0);

        // R10: samples after a closed period, before the next edge
        base = outs_seen;
        for (int i = 0; i < 5; i++) send(1000 + i);
        repeat (20) @(negedge clk);
        check(outs_seen == base, "R10", outs_seen - base, 0);

        // R8: partial period aborted by an early edge
        tag = "R8";
        raise_ref(0);
        for (int i = 0; i < 50; i++) send(9000);
        raise_ref(0);
        for (int i = 0; i < N; i++) send((i % 17) * 100 - 800);
        drain();
        check(q.size() == 0, "R8", q.size(), 0);

        // R9/R2: edge and sample in the same cycle
        tag = "R9";
        raise_ref(0);
        for (int i = 0; i < 100; i++) send(-7000);
        raise_ref(1);
        for (int i = 0; i < N; i++) send(i * 11 + 500);
        drain();
        check(q.size() == 0, "R9", q.size(), 0);
        check(outs_seen > 3 * N - 1, "R2 periods replayed", outs_seen, 4 * N);

        // next-period mode
        mode_same = 1'b0;
        do_reset();
        tag = "R6";
        base = outs_seen;
        raise_ref(0);
        for (int i = 0; i < N; i++) send(i * 3 - 200);
        repeat (4) @(negedge clk);
        check(outs_seen == base, "R6 first period silent", outs_seen - base, 0);

        tag = "R5";
        raise_ref(0);
        for (int i = 0; i < N; i++) send(2000 - i * 9);
        for (int i = 0; i < 3; i++) send(-5);

        // R7: saturation both ways
        raise_ref(0);
        for (int i = 0; i < N; i++) send(30000);
        raise_ref(0);
        for (int i = 0; i < N; i++) send(-30000);
        raise_ref(0);
        for (int i = 0; i < 10; i++) send(32767);
        repeat (10) @(negedge clk);
        check(q.size() == 0, "R5 all results seen", q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule